// File: doc/BRIEF.md
# Register Write-Protection Key Sequencer

This block sits between a simple register bus and a bank of configuration registers. Some registers in the bank are guarded: the clock time, the calendar date, the control word, the prescaler and the alarm setting. A write strobe aimed at any of them reaches the bank only after software has opened the guard. To open it, software writes two key values in a fixed order to a dedicated key register. Writes to unguarded registers always reach the bank. Reads pass through unchanged, except at the key register, which always reads as zero.

The guard has three states: closed, armed (the first key has been seen) and open. Only two bus writes in a row, first key then second key, move it from closed to open. Any deviation sends it straight back to closed. Once open, any write to the key register closes it again. The state is held in a single register. The write gating and the read-data steering are combinational, so a bus write is either forwarded or dropped in the cycle it is presented.

Top module: `wrprot_key_seq`

## Requirements
- R1: A synchronous active-high reset puts the guard in the closed state, so a write to a guarded offset presented right after reset is not forwarded.
- R2: From closed, a key write of 0xCA followed by a key write of 0x53, with no other bus write between them, opens the guard. From the next bus cycle on, writes to guarded offsets are forwarded on `reg_wr`.
- R3: In the armed state, a key write of any value other than 0x53 (including 0xCA again) returns the guard to closed, not to armed.
- R4: In the armed state, a bus write to any address other than the key register returns the guard to closed. That write itself is gated according to its own address.
- R5: In the open state, any write to the key register, whatever its value, returns the guard to closed.
- R6: The guarded byte offsets are 0x00, 0x04, 0x08, 0x10 and 0x1C. While the guard is not open, a write to any of them is dropped silently: `reg_wr` stays low and nothing else is signalled.
- R7: Writes to any other offset are forwarded whatever the guard state. Writes to the key register at offset 0x24 are never forwarded to the bank.
- R8: A read presented at offset 0x24 returns zero on `bus_rdata`. At any other offset, `bus_rdata` equals `reg_rdata` in the same cycle.
- R9: Key values are compared over the full write-data width. A value with any upper bit set, such as 0x00000153, counts as a wrong key.
- R10: In the closed state, a key write of any value other than 0xCA leaves the guard closed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Bus write strobe, one cycle per write |
| bus_addr | input | ADDR_W (10) | Byte address of the current access |
| bus_wdata | input | DATA_W (32) | Bus write data |
| reg_rdata | input | DATA_W (32) | Read data returned by the register bank |
| reg_wr | output | 1 | Gated write strobe to the register bank |
| bus_rdata | output | DATA_W (32) | Read data returned to the bus |

## Verification
`reg_wr` and `bus_rdata` are combinational, so they are judged in the same cycle the access is presented. The bench drives each access on the falling edge and samples one time unit later, well before the rising edge. A key write updates the guard at the rising edge that ends its cycle, so its effect is checked on the next write, one bus cycle later. No check therefore ever falls on the edge where the state changes. Each scenario ends with a write to a guarded offset, which exposes the guard state through `reg_wr` alone.

// File: rtl/wrprot_pkg.sv
package wrprot_pkg;

    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_ARMED  = 2'd1,
        KS_OPEN   = 2'd2
    } key_state_e;

    localparam logic [7:0] KEY_FIRST  = 8'hCA;
    localparam logic [7:0] KEY_SECOND = 8'h53;

    // decoded view of one bus access
    typedef struct packed {
        logic key_hit;
        logic prot_hit;
    } addr_class_t;

endpackage

// File: rtl/wrprot_addr_dec.sv
module wrprot_addr_dec
    import wrprot_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter logic [ADDR_W-1:0] KEY_OFFSET = 10'h024,
    parameter logic [(2**(ADDR_W-2))-1:0] PROT_MASK = 'h97
) (
    input  logic [ADDR_W-1:0] addr,
    output addr_class_t       cls
);
    localparam int WORD_W = ADDR_W - 2;

    logic              aligned;
    logic [WORD_W-1:0] word_idx;

    assign aligned  = (addr[1:0] == 2'b00);
    assign word_idx = addr[ADDR_W-1:2];

    always_comb begin
        cls.key_hit  = (addr == KEY_OFFSET);
        cls.prot_hit = aligned && PROT_MASK[word_idx];
    end
endmodule

// File: rtl/wrprot_key_fsm.sv
module wrprot_key_fsm
    import wrprot_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_key,
    input  logic              wr_other,
    input  logic [DATA_W-1:0] wdata,
    output key_state_e        state
);
    logic       is_first;
    logic       is_second;
    key_state_e nxt;

    assign is_first  = (wdata == DATA_W'(KEY_FIRST));
    assign is_second = (wdata == DATA_W'(KEY_SECOND));

    always_comb begin
        nxt = state;
        unique case (state)
            KS_LOCKED: begin
                if (wr_key && is_first)
                    nxt = KS_ARMED;
            end
            KS_ARMED: begin
                if (wr_key)
                    nxt = is_second ? KS_OPEN : KS_LOCKED;
                else if (wr_other)
                    nxt = KS_LOCKED;
            end
            KS_OPEN: begin
                if (wr_key)
                    nxt = KS_LOCKED;
            end
            default: nxt = KS_LOCKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= KS_LOCKED;
        else
            state <= nxt;
    end
endmodule

// File: rtl/wrprot_wr_gate.sv
module wrprot_wr_gate
    import wrprot_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              wr,
    input  addr_class_t       cls,
    input  key_state_e        state,
    input  logic [DATA_W-1:0] rdata_in,
    output logic              wr_out,
    output logic [DATA_W-1:0] rdata_out
);
    logic open;

    assign open = (state == KS_OPEN);

    always_comb begin
        wr_out    = wr && !cls.key_hit && (!cls.prot_hit || open);
        rdata_out = cls.key_hit ? '0 : rdata_in;
    end
endmodule

// File: rtl/wrprot_key_seq.sv
module wrprot_key_seq
    import wrprot_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] KEY_OFFSET = 10'h024,
    parameter logic [(2**(ADDR_W-2))-1:0] PROT_MASK = 'h97
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              reg_wr,
    output logic [DATA_W-1:0] bus_rdata
);
    addr_class_t cls;
    key_state_e  ks_state;
    logic        wr_key;
    logic        wr_other;

    wrprot_addr_dec #(
        .ADDR_W    (ADDR_W),
        .KEY_OFFSET(KEY_OFFSET),
        .PROT_MASK (PROT_MASK)
    ) u_dec (
        .addr(bus_addr),
        .cls (cls)
    );

    assign wr_key   = bus_wr && cls.key_hit;
    assign wr_other = bus_wr && !cls.key_hit;

    wrprot_key_fsm #(
        .DATA_W(DATA_W)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .wr_key  (wr_key),
        .wr_other(wr_other),
        .wdata   (bus_wdata),
        .state   (ks_state)
    );

    wrprot_wr_gate #(
        .DATA_W(DATA_W)
    ) u_gate (
        .wr       (bus_wr),
        .cls      (cls),
        .state    (ks_state),
        .rdata_in (reg_rdata),
        .wr_out   (reg_wr),
        .rdata_out(bus_rdata)
    );
endmodule

// File: rtl/wrprot_key_seq_chk.sv
module wrprot_key_seq_chk
    import wrprot_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] KEY_OFFSET = 10'h024,
    parameter logic [(2**(ADDR_W-2))-1:0] PROT_MASK = 'h97
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              reg_wr,
    input logic [DATA_W-1:0] bus_rdata,
    input key_state_e        ks_state
);
    logic at_key;
    logic at_prot;
    logic val_second;

    assign at_key     = (bus_addr == KEY_OFFSET);
    assign at_prot    = (bus_addr[1:0] == 2'b00) && PROT_MASK[bus_addr[ADDR_W-1:2]];
    assign val_second = (bus_wdata == DATA_W'(KEY_SECOND));

    AST_RESET_CLOSED: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ks_state == KS_LOCKED);                             // R1
    AST_SECOND_KEY_OPENS: assert property (@(posedge clk) disable iff (rst)
        (ks_state == KS_ARMED && bus_wr && at_key && val_second)
        |=> ks_state == KS_OPEN);                                          // R2
    AST_ARMED_BREAK: assert property (@(posedge clk) disable iff (rst)
        (ks_state == KS_ARMED && bus_wr && !(at_key && val_second))
        |=> ks_state == KS_LOCKED);                                        // R3
    AST_OPEN_RELOCK: assert property (@(posedge clk) disable iff (rst)
        (ks_state == KS_OPEN && bus_wr && at_key)
        |=> ks_state == KS_LOCKED);                                        // R5
    AST_GUARD_DROPS: assert property (@(posedge clk) disable iff (rst)
        (ks_state != KS_OPEN && bus_wr && at_prot) |-> !reg_wr);           // R6
    AST_KEY_NOT_FWD: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && at_key) |-> !reg_wr);                                   // R7
    AST_PLAIN_FWD: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !at_key && !at_prot) |-> reg_wr);                       // R7
    AST_KEY_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        at_key |-> bus_rdata == '0);                                       // R8
    AST_READ_PASS: assert property (@(posedge clk) disable iff (rst)
        !at_key |-> bus_rdata == reg_rdata);                               // R8
endmodule

bind wrprot_key_seq wrprot_key_seq_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .KEY_OFFSET(KEY_OFFSET),
    .PROT_MASK (PROT_MASK)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .reg_rdata(reg_rdata),
    .reg_wr   (reg_wr),
    .bus_rdata(bus_rdata),
    .ks_state (ks_state)
);

// File: tb/wrprot_key_seq_tb.sv
module wrprot_key_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [9:0] A_TIME  = 10'h000;
    localparam logic [9:0] A_DATE  = 10'h004;
    localparam logic [9:0] A_CTRL  = 10'h008;
    localparam logic [9:0] A_STAT  = 10'h00C;
    localparam logic [9:0] A_PRESC = 10'h010;
    localparam logic [9:0] A_ALARM = 10'h01C;
    localparam logic [9:0] A_FREE  = 10'h020;
    localparam logic [9:0] A_KEY   = 10'h024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] reg_rdata = '0;
    logic        reg_wr;
    logic [31:0] bus_rdata;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wrprot_key_seq u_dut (
        .clk      (clk),
        .rst      (rst),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .reg_rdata(reg_rdata),
        .reg_wr   (reg_wr),
        .bus_rdata(bus_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [9:0] a, input logic [31:0] d, output logic fwd);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        #1 fwd = reg_wr;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [9:0] a, input logic [31:0] bank, output logic [31:0] r);
        @(negedge clk);
        bus_addr  = a;
        reg_rdata = bank;
        #1 r = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic open_guard();
        logic f;
        bus_write(A_KEY, 32'h0000_00CA, f);
        bus_write(A_KEY, 32'h0000_0053, f);
    endtask

    task automatic t_reset_state();
        logic f;
        logic [31:0] r;
        do_reset();
        bus_write(A_CTRL, 32'h1, f);
        check("R1 guarded write after reset", {31'b0, f}, 32'd0);
        bus_read(A_KEY, 32'hDEAD_BEEF, r);
        check("R8 key register reads zero", r, 32'h0);
        bus_read(A_STAT, 32'hDEAD_BEEF, r);
        check("R8 other read passes bank data", r, 32'hDEAD_BEEF);
    endtask

    task automatic t_locked_drops();
        logic f;
        logic [9:0] prot [5] = '{A_TIME, A_DATE, A_CTRL, A_PRESC, A_ALARM};
        do_reset();
        for (int i = 0; i < 5; i++) begin
            bus_write(prot[i], 32'h55, f);
            check("R6 guarded write dropped while closed", {31'b0, f}, 32'd0);
        end
    endtask

    task automatic t_unguarded();
        logic f;
        do_reset();
        bus_write(A_STAT, 32'h7, f);
        check("R7 unguarded 0x0C forwarded while closed", {31'b0, f}, 32'd1);
        bus_write(A_FREE, 32'h7, f);
        check("R7 unguarded 0x20 forwarded while closed", {31'b0, f}, 32'd1);
        bus_write(A_KEY, 32'hFF, f);
        check("R7 key write not forwarded", {31'b0, f}, 32'd0);
        open_guard();
        bus_write(A_STAT, 32'h7, f);
        check("R7 unguarded forwarded while open", {31'b0, f}, 32'd1);
        bus_write(A_KEY, 32'h53, f);
        check("R7 key write not forwarded while open", {31'b0, f}, 32'd0);
    endtask

    task automatic t_unlock();
        logic f;
        logic [9:0] prot [5] = '{A_TIME, A_DATE, A_CTRL, A_PRESC, A_ALARM};
        do_reset();
        open_guard();
        for (int i = 0; i < 5; i++) begin
            bus_write(prot[i], 32'h1, f);
            check("R2 guarded write forwarded after keys", {31'b0, f}, 32'd1);
        end
    endtask

    task automatic t_relock();
        logic f;
        do_reset();
        open_guard();
        bus_write(A_KEY, 32'hFF, f);
        bus_write(A_CTRL, 32'h1, f);
        check("R5 wrong key relocks open guard", {31'b0, f}, 32'd0);
        open_guard();
        bus_write(A_KEY, 32'hCA, f);
        bus_write(A_KEY, 32'h53, f);
        bus_write(A_TIME, 32'h1, f);
        check("R5 first key while open closes, not arms", {31'b0, f}, 32'd0);
    endtask

    task automatic t_wrong_second();
        logic f;
        do_reset();
        bus_write(A_KEY, 32'hCA, f);
        bus_write(A_KEY, 32'hCA, f);
        bus_write(A_KEY, 32'h53, f);
        bus_write(A_DATE, 32'h1, f);
        check("R3 repeated first key returns to closed", {31'b0, f}, 32'd0);
        bus_write(A_KEY, 32'hCA, f);
        bus_write(A_KEY, 32'h11, f);
        bus_write(A_KEY, 32'h53, f);
        bus_write(A_DATE, 32'h1, f);
        check("R3 wrong second key returns to closed", {31'b0, f}, 32'd0);
    endtask

    task automatic t_interleave();
        logic f;
        do_reset();
        bus_write(A_KEY, 32'hCA, f);
        bus_write(A_STAT, 32'h3, f);
        check("R4 intervening unguarded write forwarded", {31'b0, f}, 32'd1);
        bus_write(A_KEY, 32'h53, f);
        bus_write(A_PRESC, 32'h1, f);
        check("R4 intervening write breaks sequence", {31'b0, f}, 32'd0);
        bus_write(A_KEY, 32'hCA, f);
        bus_write(A_ALARM, 32'h3, f);
        check("R4 intervening guarded write dropped", {31'b0, f}, 32'd0);
        bus_write(A_KEY, 32'h53, f);
        bus_write(A_PRESC, 32'h1, f);
        check("R4 guarded intervening write breaks sequence", {31'b0, f}, 32'd0);
    endtask

    task automatic t_wrong_first();
        logic f;
        do_reset();
        bus_write(A_KEY, 32'h53, f);
        bus_write(A_ALARM, 32'h1, f);
        check("R10 second key alone keeps closed", {31'b0, f}, 32'd0);
        bus_write(A_KEY, 32'h53, f);
        bus_write(A_KEY, 32'hCA, f);
        bus_write(A_KEY, 32'h00, f);
        bus_write(A_ALARM, 32'h1, f);
        check("R10 reversed order keeps closed", {31'b0, f}, 32'd0);
    endtask

    task automatic t_full_width();
        logic f;
        do_reset();
        bus_write(A_KEY, 32'hCA, f);
        bus_write(A_KEY, 32'h0000_0153, f);
        bus_write(A_CTRL, 32'h1, f);
        check("R9 upper bits make second key wrong", {31'b0, f}, 32'd0);
        bus_write(A_KEY, 32'h8000_00CA, f);
        bus_write(A_KEY, 32'h53, f);
        bus_write(A_CTRL, 32'h1, f);
        check("R9 upper bits make first key wrong", {31'b0, f}, 32'd0);
        open_guard();
        bus_write(A_CTRL, 32'h1, f);
        check("R9 exact keys open the guard", {31'b0, f}, 32'd1);
    endtask

    task automatic t_reset_while_open();
        logic f;
        do_reset();
        open_guard();
        do_reset();
        bus_write(A_TIME, 32'h1, f);
        check("R1 reset closes an open guard", {31'b0, f}, 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset_state();
        t_locked_drops();
        t_unguarded();
        t_unlock();
        t_relock();
        t_wrong_second();
        t_interleave();
        t_wrong_first();
        t_full_width();
        t_reset_while_open();
        repeat (2) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule